// File: doc/BRIEF.md
# Full-Duplex Byte Serial Transceiver

This block is a synchronous serial port that swaps one byte with a partner per transfer. A single buffer register holds the byte to send. The same register receives the byte that was clocked in. The host reaches the block through a small register port with a two-bit address. Writing the buffer and then setting the start bit begins an exchange. Each finished byte raises a one-cycle interrupt.

The serial clock has two sources. In internal mode the block drives the clock itself, from a divider of the system clock. After each byte the clock stops until the host has read the received byte and then written the next one. In external mode the block follows a clock on an input pin. Both that clock and the serial data input pass through two-flop synchronizers. Shifting goes on whether or not the host keeps up. A transfer can end in two ways. Clearing the start bit lets the current byte complete. Setting the abort bit stops the transfer on the spot.

Top module: `sio_xcvr`

## Requirements
- R1: After reset, busy reads 0, `sck_o` is 1, `sdo` is 1, `irq` is 0 and `sck_oe` is 1.
- R2: Address 0 is the shared buffer. Address 1 is control: bit 0 = start, bit 1 = abort, bit 2 = external clock. Address 2 is status, with bit 0 = busy. Reads return data on `host_rdata` one cycle after `host_rd`. Writing the buffer and then writing control with start=1 sets busy and begins a transfer.
- R3: Bits leave on `sdo` least significant first. `sdo` changes only after falling serial clock edges. `sdi` is sampled at rising edges.
- R4: After DATA_W rising edges, the received byte is in the buffer and `irq` is high for exactly one cycle.
- R5: The internal serial clock idles high, and each of its low phases lasts CLK_DIV system clocks.
- R6: In internal mode with start still set, after each byte `sck_o` stays high and busy stays 1. This lasts until the buffer has been read and then written.
- R7: In external mode there is no wait state, and busy stays 1 between bytes. If the buffer is not rewritten, the next byte sends the previously received byte.
- R8: At the start of a byte, `sdo` keeps the last bit of the previous byte until the first falling edge.
- R9: If start is cleared during a byte, that byte completes, lands in the buffer and raises `irq`. Busy then reads 0. If start is cleared between bytes, busy drops at once.
- R10: Writing control with abort=1 clears busy on the next cycle and returns `sck_o` high. No `irq` follows, and the buffer keeps its contents.
- R11: `sck_oe` is 1 in internal clock mode and 0 in external clock mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | One-cycle end-of-byte pulse |
| sck_o | output | 1 | Serial clock driven in internal mode |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | External serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The bench builds the block with DATA_W=8 and CLK_DIV=3. A short divider keeps each internal byte to a few dozen cycles. That makes room for an exhaustive sweep of all 256 byte values in one continuous internal loopback transfer. Every byte in the sweep passes through the wait state and is checked for LSB-first order, last-bit hold and low-phase width. The same configuration is then driven as an external-clock slave with a slow clock. This reaches the stale-byte and overwrite behaviour, along with the graceful stop and abort paths.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;
  localparam int CTRL_START = 0;
  localparam int CTRL_ABORT = 1;
  localparam int CTRL_EXT   = 2;
  localparam int STAT_BUSY  = 0;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sio_sck_gen.sv
module sio_sck_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sck,
  output logic fall_stb,
  output logic rise_stb
);
  localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt      <= '0;
      sck      <= 1'b1;
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
    end else if (cnt == DIV_LAST) begin
      cnt      <= '0;
      sck      <= ~sck;
      fall_stb <= sck;
      rise_stb <= ~sck;
    end else begin
      cnt      <= cnt + 1'b1;
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_xcvr.sv
module sio_xcvr
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CLK_DIV = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sck_i,
  input  logic              sdi,
  output logic              sdo
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] buf_q, shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic half, busy, waiting, rd_seen, wr_seen;
  logic ctrl_start, ctrl_abort, ctrl_ext;
  logic sck_s, sdi_s, sck_prev;
  logic gen_fall, gen_rise, run;
  logic fall_evt, rise_evt, in_byte;
  logic data_wr, data_rd, ctrl_wr;

  sio_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d({sck_i, sdi}), .q({sck_s, sdi_s})
  );

  assign run = busy & ~ctrl_ext & ~waiting;

  sio_sck_gen #(.CLK_DIV(CLK_DIV)) u_gen (
    .clk(clk), .rst(rst), .run(run),
    .sck(sck_o), .fall_stb(gen_fall), .rise_stb(gen_rise)
  );

  assign fall_evt = ctrl_ext ? (sck_prev & ~sck_s) : gen_fall;
  assign rise_evt = ctrl_ext ? (~sck_prev & sck_s) : gen_rise;
  assign in_byte  = half | (bit_cnt != '0);
  assign data_wr  = host_wr && host_addr == ADDR_DATA;
  assign data_rd  = host_rd && host_addr == ADDR_DATA;
  assign ctrl_wr  = host_wr && host_addr == ADDR_CTRL;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0; shreg <= '0; bit_cnt <= '0; half <= 1'b0;
      busy <= 1'b0; waiting <= 1'b0; rd_seen <= 1'b0; wr_seen <= 1'b0;
      ctrl_start <= 1'b0; ctrl_abort <= 1'b0; ctrl_ext <= 1'b0;
      sck_prev <= 1'b1; sdo <= 1'b1; irq <= 1'b0; sck_oe <= 1'b1;
      host_rdata <= '0;
    end else begin
      irq      <= 1'b0;
      sck_prev <= sck_s;
      sck_oe   <= ~ctrl_ext;
      if (host_rd) begin
        case (host_addr)
          ADDR_DATA: host_rdata <= buf_q;
          ADDR_CTRL: host_rdata <= DATA_W'({ctrl_ext, ctrl_abort, ctrl_start});
          ADDR_STAT: host_rdata <= DATA_W'(busy) << STAT_BUSY;
          default:   host_rdata <= '0;
        endcase
      end
      if (data_wr) begin
        buf_q <= host_wdata;
        if (waiting && rd_seen) wr_seen <= 1'b1;
      end
      if (data_rd && waiting) rd_seen <= 1'b1;
      if (ctrl_wr) begin
        ctrl_start <= host_wdata[CTRL_START] & ~host_wdata[CTRL_ABORT];
        ctrl_abort <= host_wdata[CTRL_ABORT];
        ctrl_ext   <= host_wdata[CTRL_EXT];
      end

      if (ctrl_wr && host_wdata[CTRL_ABORT]) begin
        busy <= 1'b0; waiting <= 1'b0; bit_cnt <= '0; half <= 1'b0;
      end else if (ctrl_wr && host_wdata[CTRL_START] && !busy) begin
        busy <= 1'b1; waiting <= 1'b0; bit_cnt <= '0; half <= 1'b0;
      end else if (busy) begin
        if (!ctrl_start && !in_byte) begin
          busy    <= 1'b0;
          waiting <= 1'b0;
        end else if (waiting) begin
          if (rd_seen && wr_seen) waiting <= 1'b0;
        end else begin
          if (fall_evt) begin
            half <= 1'b1;
            if (bit_cnt == '0) begin
              shreg <= buf_q;
              sdo   <= buf_q[0];
            end else begin
              sdo <= shreg[0];
            end
          end
          if (rise_evt && half) begin
            half  <= 1'b0;
            shreg <= {sdi_s, shreg[DATA_W-1:1]};
            if (bit_cnt == LAST_BIT) begin
              buf_q   <= {sdi_s, shreg[DATA_W-1:1]};
              irq     <= 1'b1;
              bit_cnt <= '0;
              if (!ctrl_start) begin
                busy <= 1'b0;
              end else if (!ctrl_ext) begin
                waiting <= 1'b1;
                rd_seen <= 1'b0;
                wr_seen <= 1'b0;
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/sio_xcvr_chk.sv
module sio_xcvr_chk (
  input logic clk,
  input logic rst,
  input logic ctrl_abort_wr,
  input logic irq,
  input logic sck_o,
  input logic sdo,
  input logic busy
);
  // R4
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst) irq |=> !irq);
  // R4
  irq_busy_chk: assert property (@(posedge clk) disable iff (rst) irq |-> $past(busy));
  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst) ctrl_abort_wr |=> (!busy && !irq));
  // R5
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst) (!busy && $past(!busy)) |-> sck_o);
  // R8
  sdo_hold_chk: assert property (@(posedge clk) disable iff (rst) !$past(busy) |-> $stable(sdo));
endmodule

bind sio_xcvr sio_xcvr_chk u_chk (
  .clk(clk),
  .rst(rst),
  .ctrl_abort_wr(host_wr && (host_addr == sio_pkg::ADDR_CTRL) && host_wdata[sio_pkg::CTRL_ABORT]),
  .irq(irq),
  .sck_o(sck_o),
  .sdo(sdo),
  .busy(busy)
);

// File: tb/test_sio_xcvr.sv
module test_sio_xcvr;
  localparam int DW = 8, DIV = 3, HALF = 10;
  localparam logic [1:0] A_DATA = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0, host_rdata;
  logic irq, sck_o, sck_oe, sdo;
  logic sck_i = 1'b1, sdi_drv = 1'b1, ext_phase = 1'b0;
  wire sdi_w = ext_phase ? sdi_drv : sdo;

  sio_xcvr #(.DATA_W(DW), .CLK_DIV(DIV)) i_sio_xcvr (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq), .sck_o(sck_o),
    .sck_oe(sck_oe), .sck_i(sck_i), .sdi(sdi_w), .sdo(sdo)
  );

  int checks = 0, errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  int irq_cnt = 0, mon_cnt = 0, since_chg = 0;
  logic [DW-1:0] mon_byte = '0, mon_last = '0;
  logic sck_seen = 1'b1;

  always @(negedge clk) begin
    if (rst) begin
      irq_cnt = 0; mon_cnt = 0; since_chg = 0; sck_seen = 1'b1;
    end else begin
      if (irq) irq_cnt++;
      since_chg++;
      if (sck_o !== sck_seen) begin
        if (sck_o) begin
          chk("R5 low phase", since_chg, DIV);
          mon_byte = {sdo, mon_byte[DW-1:1]};
          mon_cnt++;
          if (mon_cnt == DW) begin mon_last = mon_byte; mon_cnt = 0; end
        end
        since_chg = 0;
        sck_seen = sck_o;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    @(negedge clk); host_rd = 1'b0; d = host_rdata;
  endtask

  task automatic ext_byte(input logic [DW-1:0] o, output logic [DW-1:0] g);
    for (int i = 0; i < DW; i++) begin
      @(negedge clk); sck_i = 1'b0; sdi_drv = o[i];
      repeat (HALF) @(negedge clk);
      g[i] = sdo; sck_i = 1'b1;
      repeat (HALF - 1) @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] d, g, nxt;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sck_o", sck_o, 1); chk("R1 sdo", sdo, 1); chk("R1 irq", irq, 0);
    chk("R1 sck_oe", sck_oe, 1);
    rd(A_STAT, d); chk("R1 busy", d, 0);

    // internal loopback sweep over every byte value
    wr(A_DATA, 8'h00);
    wr(A_CTRL, 8'h01);
    chk("R8 first hold", sdo, 1);
    rd(A_STAT, d); chk("R2 busy after start", d, 1);
    rd(A_CTRL, d); chk("R2 ctrl readback", d, 1);
    chk("R11 internal oe", sck_oe, 1);
    for (int v = 0; v < 256; v++) begin
      wait (irq_cnt == v + 1);
      @(negedge clk);
      chk("R3 lsb first", mon_last, v);
      if (v < 3) begin
        repeat (8) @(negedge clk);
        chk("R6 sck stalled", sck_o, 1);
        rd(A_STAT, d); chk("R6 busy in wait", d, 1);
      end
      rd(A_DATA, d); chk("R4 received", d, v);
      if (v < 3) begin
        repeat (8) @(negedge clk);
        chk("R6 read alone keeps wait", sck_o, 1);
        chk("R6 no bits", mon_cnt, 0);
      end
      nxt = (v == 255) ? 8'h5A : DW'(v + 1);
      wr(A_DATA, nxt);
      chk("R8 last bit held", sdo, v[7]);
    end
    chk("R4 irq count", irq_cnt, 256);

    // graceful stop mid-byte
    wait (mon_cnt == 4);
    wr(A_CTRL, 8'h00);
    wait (irq_cnt == 257);
    @(negedge clk);
    chk("R9 byte finished", mon_last, 8'h5A);
    repeat (4) @(negedge clk);
    rd(A_STAT, d); chk("R9 busy cleared", d, 0);
    rd(A_DATA, d); chk("R9 buffer", d, 8'h5A);
    repeat (20) @(negedge clk);
    chk("R9 clock idle", sck_o, 1); chk("R9 single irq", irq_cnt, 257);

    // abort mid-byte
    wr(A_DATA, 8'h3C);
    wr(A_CTRL, 8'h01);
    chk("R8 hold after stop", sdo, 0);
    wait (mon_cnt == 3);
    wr(A_CTRL, 8'h02);
    rd(A_STAT, d); chk("R10 busy cleared", d, 0);
    rd(A_CTRL, d); chk("R2 abort readback", d, 2);
    repeat (40) @(negedge clk);
    chk("R10 no irq", irq_cnt, 257); chk("R10 clock idle", sck_o, 1);
    rd(A_DATA, d); chk("R10 buffer kept", d, 8'h3C);

    // external clock mode
    rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0;
    ext_phase = 1'b1;
    wr(A_DATA, 8'hC3);
    wr(A_CTRL, 8'h05);
    @(negedge clk);
    chk("R11 external oe", sck_oe, 0);
    ext_byte(8'h96, g); chk("R3 external lsb first", g, 8'hC3);
    repeat (6) @(negedge clk);
    chk("R4 external irq", irq_cnt, 1);
    rd(A_DATA, d); chk("R4 external received", d, 8'h96);
    rd(A_STAT, d); chk("R7 busy between bytes", d, 1);
    ext_byte(8'h2D, g); chk("R7 stale resend", g, 8'h96);
    repeat (6) @(negedge clk);
    rd(A_DATA, d); chk("R7 overwritten", d, 8'h2D);
    wr(A_DATA, 8'hE8);
    ext_byte(8'h71, g); chk("R7 serviced send", g, 8'hE8);
    repeat (6) @(negedge clk);
    rd(A_DATA, d); chk("R7 third received", d, 8'h71);
    chk("R4 external irq count", irq_cnt, 3);
    chk("R11 sck_o idle", sck_o, 1);
    wr(A_CTRL, 8'h04);
    repeat (2) @(negedge clk);
    rd(A_STAT, d); chk("R9 stop between bytes", d, 0);

    summary();
    $finish;
  end
endmodule